// File: doc/BRIEF.md
# Oversampled Burst DDR Receiver

This block accepts a single-ended, source-synchronous, double-data-rate bus. The forwarded clock on that bus toggles only while a burst is being sent. The forwarded clock is never used as a clock. A fast system clock, at least four times the forwarded rate, samples the forwarded clock and the data lines. Each sampled line passes through its own synchronizer. The block detects every rising and falling transition of the forwarded clock and takes one data sample at each one. A sample taken at a rising transition and the sample taken at the next falling transition are joined into one word of twice the bus width.

No forwarded edge follows the last item of a burst. An idle timer therefore watches the gap since the last detected transition. When a word is still waiting for its falling-edge half and the gap reaches a set limit, the word is emitted anyway and marked as odd-length. Finished words collect in a small output queue. The queue drives a valid/ready interface in the system clock domain. A sticky flag records any word that is lost because the queue was full.

Top module: `ddr_burst_rx`

## Requirements
- R1: During and just after a synchronous active-high reset, `word_valid` and `overflow` are 0.
- R2: A sample taken at a rising transition of `bus_clk` becomes bits [N-1:0] of a word. The sample taken at the following falling transition becomes bits [2N-1:N] of the same word. Such a word carries `word_odd` = 0.
- R3: Only the value of `bus_dat` in the window around a transition is captured. Changes of `bus_dat` while `bus_clk` is steady have no effect on any word.
- R4: If IDLE_CYCLES system cycles pass with no transition while a word holds only its rising-edge half, the word is emitted with `word_odd` = 1 and bits [2N-1:N] equal to 0.
- R5: Transitions spaced by fewer than IDLE_CYCLES system cycles never trigger the idle flush. This holds at a spacing of IDLE_CYCLES-1.
- R6: A falling transition that arrives while no rising-edge half is pending creates no word.
- R7: Words leave in arrival order. Up to DEPTH words are held while `word_ready` is 0. `word_data` and `word_odd` stay steady while `word_valid` is 1 and `word_ready` is 0.
- R8: A word that completes while DEPTH words are already held is dropped, and `overflow` becomes 1. `overflow` then stays 1 until reset, and the held words are unaffected.
- R9: Reset empties the queue and clears `overflow` and the pairing state.
- R10: After an idle flush, the next rising transition starts a new word as its low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System sampling clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Forwarded bus clock, sampled as data |
| bus_dat | input | N | Bus data lines |
| word_valid | output | 1 | A word is available |
| word_ready | input | 1 | Consumer accepts the word |
| word_data | output | 2N | Assembled word, rising-edge half in the low bits |
| word_odd | output | 1 | Word was closed by the idle timeout |
| overflow | output | 1 | Sticky: a word was dropped while the queue was full |

## Verification
The bench builds the block with N = 4, IDLE_CYCLES = 8 and DEPTH = 4. A 4-bit bus lets random data reach every bit pattern in both halves of a word. A limit of 8 cycles lets the bench space forwarded edges at 5 cycles and also at 7 cycles, one short of the flush limit. A 4-entry queue fills and overflows after only five words while `word_ready` is held low. Odd-length bursts are parked with the forwarded clock high, which makes each of them produce both an idle flush and a stray falling transition.

// File: rtl/ddr_burst_rx_pkg.sv
package ddr_burst_rx_pkg;

    // Which half of a word the pairing logic waits for next.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pair_phase_e;

    // Transition event on the sampled forwarded clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic edge_ev_t classify_edge(input logic now_v, input logic before_v);
        edge_ev_t ev;
        ev.rise = now_v & ~before_v;
        ev.fall = ~now_v & before_v;
        return ev;
    endfunction

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/ddr_burst_rx_sync.sv
module ddr_burst_rx_sync #(
    parameter int N           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         bus_clk,
    input  logic [N-1:0] bus_dat,
    output logic         clk_now,
    output logic         clk_prev,
    output logic [N-1:0] dat_smp
);
    localparam int W = N + 1;

    logic [W-1:0] raw;
    logic [W-1:0] synced;
    logic         clk_q;
    logic [N-1:0] dat_q;

    assign raw = {bus_clk, bus_dat};

    // One independent synchronizer chain per sampled line.
    for (genvar b = 0; b < W; b++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge sys_clk) begin
            if (sys_rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw[b]};
            end
        end
        assign synced[b] = chain[SYNC_STAGES-1];
    end

    // Previous clock value for edge detection; data delayed one cycle
    // so the sample lands inside the valid window, not on a transition.
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            clk_q <= 1'b0;
            dat_q <= '0;
        end else begin
            clk_q <= synced[N];
            dat_q <= synced[N-1:0];
        end
    end

    assign clk_now  = synced[N];
    assign clk_prev = clk_q;
    assign dat_smp  = dat_q;
endmodule

// File: rtl/ddr_burst_rx_pair.sv
module ddr_burst_rx_pair
    import ddr_burst_rx_pkg::*;
#(
    parameter int N           = 4,
    parameter int IDLE_CYCLES = 8
) (
    input  logic           sys_clk,
    input  logic           sys_rst,
    input  edge_ev_t       ev,
    input  logic [N-1:0]   dat_smp,
    output logic           push,
    output logic [2*N-1:0] word,
    output logic           odd
);
    localparam int CW = (IDLE_CYCLES < 2) ? 1 : $clog2(IDLE_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES - 1);

    pair_phase_e  phase_q, phase_n;
    logic [N-1:0] low_q, low_n;
    logic [CW-1:0] idle_q, idle_n;
    logic          any_edge;
    logic          flush;

    assign any_edge = ev.rise | ev.fall;
    assign flush    = (phase_q == PH_HIGH) && !any_edge && (idle_q == LIMIT);

    always_comb begin
        phase_n = phase_q;
        low_n   = low_q;
        push    = 1'b0;
        odd     = 1'b0;
        word    = {{N{1'b0}}, low_q};
        if (phase_q == PH_LOW) begin
            if (ev.rise) begin
                low_n   = dat_smp;
                phase_n = PH_HIGH;
            end
        end else begin
            if (ev.fall) begin
                push    = 1'b1;
                word    = {dat_smp, low_q};
                phase_n = PH_LOW;
            end else if (flush) begin
                push    = 1'b1;
                odd     = 1'b1;
                phase_n = PH_LOW;
            end
        end
    end

    always_comb begin
        if (any_edge) begin
            idle_n = '0;
        end else if (idle_q != LIMIT) begin
            idle_n = idle_q + 1'b1;
        end else begin
            idle_n = idle_q;
        end
    end

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            phase_q <= PH_LOW;
            low_q   <= '0;
            idle_q  <= '0;
        end else begin
            phase_q <= phase_n;
            low_q   <= low_n;
            idle_q  <= idle_n;
        end
    end
endmodule

// File: rtl/ddr_burst_rx_fifo.sv
module ddr_burst_rx_fifo
    import ddr_burst_rx_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic         ovf
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full      = (cnt_q == FULLC);
    assign out_valid = (cnt_q != '0);
    assign do_pop    = out_valid && out_ready;
    assign do_push   = push && !full;
    assign out_data  = mem[rd_q];

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= push_data;
                wr_q      <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/ddr_burst_rx.sv
module ddr_burst_rx
    import ddr_burst_rx_pkg::*;
#(
    parameter int N           = 4,
    parameter int IDLE_CYCLES = 8,
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           sys_clk,
    input  logic           sys_rst,
    input  logic           bus_clk,
    input  logic [N-1:0]   bus_dat,
    output logic           word_valid,
    input  logic           word_ready,
    output logic [2*N-1:0] word_data,
    output logic           word_odd,
    output logic           overflow
);
    localparam int WW = 2 * N + 1;

    logic           clk_now, clk_prev;
    logic [N-1:0]   dat_smp;
    edge_ev_t       ev;
    logic           push;
    logic [2*N-1:0] word;
    logic           odd;
    logic [WW-1:0]  q_out;

    ddr_burst_rx_sync #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .bus_clk (bus_clk),
        .bus_dat (bus_dat),
        .clk_now (clk_now),
        .clk_prev(clk_prev),
        .dat_smp (dat_smp)
    );

    assign ev = classify_edge(clk_now, clk_prev);

    ddr_burst_rx_pair #(.N(N), .IDLE_CYCLES(IDLE_CYCLES)) u_pair (
        .sys_clk(sys_clk),
        .sys_rst(sys_rst),
        .ev     (ev),
        .dat_smp(dat_smp),
        .push   (push),
        .word   (word),
        .odd    (odd)
    );

    ddr_burst_rx_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .push     (push),
        .push_data({odd, word}),
        .out_valid(word_valid),
        .out_ready(word_ready),
        .out_data (q_out),
        .ovf      (overflow)
    );

    assign word_odd  = q_out[WW-1];
    assign word_data = q_out[2*N-1:0];
endmodule

// File: rtl/ddr_burst_rx_chk.sv
module ddr_burst_rx_chk #(
    parameter int N = 4
) (
    input logic           sys_clk,
    input logic           sys_rst,
    input logic           word_valid,
    input logic           word_ready,
    input logic [2*N-1:0] word_data,
    input logic           word_odd,
    input logic           overflow
);
    // R1 and R9: reset leaves nothing pending
    p_reset_clear_r1: assert property (@(posedge sys_clk)
        sys_rst |=> (!word_valid && !overflow));

    // R4: an odd-length word has an empty high half
    p_odd_high_zero_r4: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (word_valid && word_odd) |-> (word_data[2*N-1:N] == '0));

    // R7: an offered word stays put until it is taken
    p_hold_stable_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (word_valid && !word_ready) |=>
            (word_valid && $stable(word_data) && $stable(word_odd)));

    // R8: the overflow flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
        overflow |=> overflow);
endmodule

bind ddr_burst_rx ddr_burst_rx_chk #(.N(N)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .word_valid(word_valid),
    .word_ready(word_ready),
    .word_data (word_data),
    .word_odd  (word_odd),
    .overflow  (overflow)
);

// File: tb/ddr_burst_rx_tb.sv
module ddr_burst_rx_tb;
    localparam int N    = 4;
    localparam int IDLE = 8;
    localparam int DEP  = 4;

    logic           sys_clk = 1'b0;
    logic           sys_rst = 1'b1;
    logic           bus_clk = 1'b0;
    logic [N-1:0]   bus_dat = '0;
    logic           word_valid;
    logic           word_ready = 1'b0;
    logic [2*N-1:0] word_data;
    logic           word_odd;
    logic           overflow;

    int n_cmp = 0;
    int n_bad = 0;
    bit stall_all = 1'b0;
    bit done = 1'b0;
    logic [2*N:0] expq [$];

    always #4 sys_clk = ~sys_clk;

    ddr_burst_rx #(.N(N), .IDLE_CYCLES(IDLE), .DEPTH(DEP)) u_dut (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .bus_clk   (bus_clk),
        .bus_dat   (bus_dat),
        .word_valid(word_valid),
        .word_ready(word_ready),
        .word_data (word_data),
        .word_odd  (word_odd),
        .overflow  (overflow)
    );

    function automatic logic [2*N:0] mk_word(logic [N-1:0] lo, logic [N-1:0] hi, logic od);
        return {od, hi, lo};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Consumer: picks ready away from the edge, then scores the handshake.
    always @(negedge sys_clk) begin
        if (!sys_rst) begin
            word_ready = stall_all ? 1'b0 : ($urandom % 4 != 0);
            if (word_valid && word_ready) begin
                if (expq.size() == 0) begin
                    check("R6/R3 unexpected word", {23'd0, word_odd, word_data}, 32'hFFFF_FFFF);
                end else begin
                    // R2 pairing, R3 window capture, R4 flush, R7 order
                    check("R2/R3/R4/R7 word", {23'd0, word_odd, word_data}, {23'd0, expq.pop_front()});
                end
            end
        end
    end

    // One data item: stable before the edge, junk a while after it.
    task automatic put_sample(logic [N-1:0] v, int junk);
        bus_dat = v;
        repeat (2) @(negedge sys_clk);
        bus_clk = ~bus_clk;
        repeat (2) @(negedge sys_clk);
        bus_dat = N'($urandom);
        repeat (junk) @(negedge sys_clk);
    endtask

    task automatic send_burst(int n, int junk);
        logic [N-1:0] lo = '0;
        for (int k = 0; k < n; k++) begin
            logic [N-1:0] v = N'($urandom);
            if (k % 2 == 0) lo = v;
            else expq.push_back(mk_word(lo, v, 1'b0));
            put_sample(v, junk);
        end
        if (n % 2 == 1) begin
            expq.push_back(mk_word(lo, '0, 1'b1));
            repeat (IDLE + 6) @(negedge sys_clk);
            bus_clk = 1'b0;          // stray falling edge after flush, R6
            repeat (6) @(negedge sys_clk);
        end else begin
            repeat (IDLE + 4) @(negedge sys_clk);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (expq.size() != 0 || word_valid); i++) @(negedge sys_clk);
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge sys_clk);
        check("R1 valid after reset", 32'(word_valid), 32'd0);
        check("R1 overflow after reset", 32'(overflow), 32'd0);
        sys_rst = 1'b0;
        repeat (3) @(negedge sys_clk);

        // R2 directed: low half from rise, high half from fall
        expq.push_back(mk_word(4'hA, 4'h5, 1'b0));
        put_sample(4'hA, 1);
        put_sample(4'h5, 1);
        repeat (IDLE + 4) @(negedge sys_clk);
        drain();
        check("R2 directed drained", 32'(expq.size()), 32'd0);

        // R4 and R6 directed: single item flushed, then stray fall
        send_burst(1, 1);
        drain();
        check("R4 flush delivered", 32'(expq.size()), 32'd0);
        check("R6 no word from stray fall", 32'(word_valid), 32'd0);

        // R10: new burst after flush starts with the low half
        send_burst(4, 1);
        drain();
        check("R10 realigned after flush", 32'(expq.size()), 32'd0);

        // R5: edge spacing IDLE-1 never flushes
        send_burst(6, 3);
        drain();
        check("R5 no premature flush", 32'(expq.size()), 32'd0);

        // Random bursts with random backpressure
        for (int b = 0; b < 40; b++) begin
            send_burst(1 + int'($urandom % 12), 1 + int'($urandom % 3));
        end
        drain();
        check("R7 all random words delivered", 32'(expq.size()), 32'd0);

        // R7 and R8: fill queue with ready held low, then one more
        stall_all = 1'b1;
        @(negedge sys_clk);
        for (int w = 0; w < DEP + 1; w++) begin
            logic [N-1:0] a = N'($urandom);
            logic [N-1:0] c = N'($urandom);
            if (w < DEP) expq.push_back(mk_word(a, c, 1'b0));
            put_sample(a, 1);
            put_sample(c, 1);
        end
        repeat (IDLE + 4) @(negedge sys_clk);
        check("R8 overflow set", 32'(overflow), 32'd1);
        check("R7 head held under stall", {23'd0, word_odd, word_data}, {23'd0, expq[0]});
        repeat (5) @(negedge sys_clk);
        check("R7 head still held", {23'd0, word_odd, word_data}, {23'd0, expq[0]});
        stall_all = 1'b0;
        drain();
        check("R8 held words intact", 32'(expq.size()), 32'd0);
        check("R8 overflow sticky", 32'(overflow), 32'd1);

        // R9: reset clears overflow and queue, even with a word pending
        stall_all = 1'b1;
        put_sample(4'h3, 1);
        put_sample(4'hC, 1);
        repeat (4) @(negedge sys_clk);
        sys_rst = 1'b1;
        repeat (2) @(negedge sys_clk);
        sys_rst = 1'b0;
        stall_all = 1'b0;
        @(negedge sys_clk);
        check("R9 overflow cleared", 32'(overflow), 32'd0);
        check("R9 queue emptied", 32'(word_valid), 32'd0);

        // R9: pairing restarts cleanly after reset
        send_burst(3, 2);
        drain();
        check("R9 post-reset burst", 32'(expq.size()), 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule